// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects interrupt requests from a set of peripheral sources and decides when the processor should enter a handler. Each source has a 3-bit priority level held in its own control register. A smaller number means a more urgent source. The controller keeps a current priority mask. A pending source is taken only when its level is strictly below that mask, the global enable is set, no transfer-service operation is running, and no return strobe is present in the same cycle.

When a request is taken, the controller does three things on the same clock edge. It saves the old mask on an internal stack, loads the mask with the level it has just accepted, and gives a one-cycle accept pulse together with the index of the winning source. A return-from-interrupt strobe pops the stack and restores the mask that was in force before the matching entry. As a result, only strictly more urgent sources can preempt a running handler. Requests at the same level or a less urgent one stay pending until the handler returns. Saving and restoring processor registers, vector fetch and handler code are not part of this block.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset every source level is 7, the mask is 7, no accept is signalled and both stack flags are 0. A write with `cfg_we` high loads `cfg_lvl` into the level register of source `cfg_idx`, effective from the next cycle.
- R2: A request seen on `irq_req` at one clock edge becomes pending at that edge. If it is eligible in the following cycle, `ack` is high for one cycle after the next edge. A source is eligible only if its level is strictly less than the current mask.
- R3: A source at level 7 is never accepted, and a mask of 0 blocks every source. Either way, the request stays pending until its level or the mask allows it.
- R4: While `gie` is 0 no request is accepted, and pending requests are kept so that they are accepted once `gie` returns to 1.
- R5: Among eligible pending sources the lowest level wins. A tie goes to the lowest source index, which is reported on `ack_idx`.
- R6: On an accept the mask takes the accepted level, and the old mask is saved. On `reti` the mask returns to the value it had before the most recent unreturned accept.
- R7: A request whose level is equal to or above the running handler's level stays pending and is accepted only after the handler returns.
- R8: While `xfer_busy` is 1 no request is accepted, and pending requests are kept.
- R9: The pending bit of the accepted source clears on the accept edge, unless that source's request is high in the same cycle.
- R10: A cycle with `reti` high accepts nothing. A request that would have won is accepted in a later cycle, against the restored mask.
- R11: The saved-mask stack holds `STK_DEPTH` entries (8 by default). An accept with a full stack still loads the mask, but drops the save and sets the sticky `stk_ovf` flag.
- R12: A `reti` with an empty stack leaves the mask unchanged and sets the sticky `stk_unf` flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | N_SRC | Request lines, one per source |
| gie | input | 1 | Global interrupt enable |
| xfer_busy | input | 1 | Transfer-service operation in progress; holds off all accepts |
| reti | input | 1 | Return-from-interrupt strobe |
| cfg_we | input | 1 | Level register write enable |
| cfg_idx | input | $clog2(N_SRC) | Source whose level is written |
| cfg_lvl | input | 3 | Level value to write |
| ack | output | 1 | One-cycle accept pulse |
| ack_idx | output | $clog2(N_SRC) | Index of the most recently accepted source |
| cur_mask | output | 3 | Current priority mask |
| stk_ovf | output | 1 | Sticky flag: a save was dropped because the stack was full |
| stk_unf | output | 1 | Sticky flag: a return arrived with the stack empty |

## Verification
The assertions check on every cycle that each accept strictly lowers the mask and never leaves it at 7. They also check that no accept follows a cycle with `gie` low, `xfer_busy` high or `reti` high, and that both stack flags never clear once set. The bench scenarios are needed for the rest: which source wins a tie, that held-off requests stay pending and are taken later, that `reti` restores the exact earlier mask across nesting, that a reasserted request survives its own accept, and that overflow appears at the right depth. A cycle-level reference model in the bench covers these, driven both by directed sequences and by a long random run.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  // Mask value that admits levels 0..6 and reset value of every level.
  localparam lvl_t LVL_OPEN = '1;
endpackage

// File: rtl/nirq_pend.sv
module nirq_pend #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_req,
  input  logic          take,
  input  logic [IW-1:0] take_idx,
  output logic [N-1:0]  pend_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;
  logic [N-1:0] clr;

  always_comb begin
    clr = '0;
    if (take) clr[take_idx] = 1'b1;
    // a request high in the accept cycle re-arms the bit
    pend_d = irq_req | (pend_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/nirq_pick.sv
module nirq_pick
  import nirq_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  pend_i,
  input  lvl_t [N-1:0]  lvl_i,
  input  lvl_t          mask_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o,
  output lvl_t          lvl_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    lvl_o = LVL_OPEN;
    // strict compare keeps the lowest index on a level tie
    for (int i = 0; i < N; i++) begin
      if (pend_i[i] && (lvl_i[i] < mask_i) && (!hit_o || (lvl_i[i] < lvl_o))) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
        lvl_o = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/nirq_mstack.sv
module nirq_mstack
  import nirq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  lvl_t load_lvl,
  output lvl_t mask_o,
  output logic ovf_o,
  output logic unf_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  lvl_t          stk_q [DEPTH];
  lvl_t          mask_q, mask_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_dec;
  logic          ovf_q, ovf_d, unf_q, unf_d;
  logic          wr_en;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign cnt_dec = cnt_q - CW'(1);
  assign rd_ptr  = AW'(cnt_dec);
  assign wr_ptr  = AW'(cnt_q);

  always_comb begin
    mask_d = mask_q;
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    unf_d  = unf_q;
    wr_en  = 1'b0;
    if (pop) begin
      if (!empty) begin
        cnt_d  = cnt_dec;
        mask_d = stk_q[rd_ptr];
      end else begin
        unf_d = 1'b1;
      end
    end else if (push) begin
      if (!full) begin
        wr_en = 1'b1;
        cnt_d = cnt_q + CW'(1);
      end else begin
        ovf_d = 1'b1;
      end
      mask_d = load_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= LVL_OPEN;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
    end
  end

  // storage without reset: an entry is read only after it was written
  always_ff @(posedge clk) begin
    if (wr_en) stk_q[wr_ptr] <= mask_q;
  end

  assign mask_o = mask_q;
  assign ovf_o  = ovf_q;
  assign unf_o  = unf_q;
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nirq_pkg::*;
#(
  parameter int  N_SRC     = 8,
  parameter int  STK_DEPTH = 8,
  localparam int IW        = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_req,
  input  logic             gie,
  input  logic             xfer_busy,
  input  logic             reti,
  input  logic             cfg_we,
  input  logic [IW-1:0]    cfg_idx,
  input  logic [LVL_W-1:0] cfg_lvl,
  output logic             ack,
  output logic [IW-1:0]    ack_idx,
  output logic [LVL_W-1:0] cur_mask,
  output logic             stk_ovf,
  output logic             stk_unf
);
  logic [1:0]         rsync_q;
  logic               rst_ni;
  lvl_t [N_SRC-1:0]   lvl_q;
  logic [N_SRC-1:0]   pend;
  logic               hit;
  logic [IW-1:0]      win_idx;
  lvl_t               win_lvl;
  lvl_t               mask;
  logic               accept;
  logic               ack_q;
  logic [IW-1:0]      idx_q, idx_d;

  // reset asserts at once, leaves after two clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  for (genvar g = 0; g < N_SRC; g++) begin : g_lvl
    logic lvl_en;
    assign lvl_en = cfg_we && (cfg_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)     lvl_q[g] <= LVL_OPEN;
      else if (lvl_en) lvl_q[g] <= cfg_lvl;
    end
  end

  nirq_pend #(.N(N_SRC), .IW(IW)) u_pend (
    .clk      (clk),
    .rst_n    (rst_ni),
    .irq_req  (irq_req),
    .take     (accept),
    .take_idx (win_idx),
    .pend_o   (pend)
  );

  nirq_pick #(.N(N_SRC), .IW(IW)) u_pick (
    .pend_i (pend),
    .lvl_i  (lvl_q),
    .mask_i (mask),
    .hit_o  (hit),
    .idx_o  (win_idx),
    .lvl_o  (win_lvl)
  );

  // a return in the same cycle wins over any accept
  assign accept = hit && gie && !xfer_busy && !reti;

  nirq_mstack #(.DEPTH(STK_DEPTH)) u_stk (
    .clk      (clk),
    .rst_n    (rst_ni),
    .push     (accept),
    .pop      (reti),
    .load_lvl (win_lvl),
    .mask_o   (mask),
    .ovf_o    (stk_ovf),
    .unf_o    (stk_unf)
  );

  always_comb begin
    idx_d = idx_q;
    if (accept) idx_d = win_idx;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      idx_q <= '0;
    end else begin
      ack_q <= accept;
      idx_q <= idx_d;
    end
  end

  assign ack      = ack_q;
  assign ack_idx  = idx_q;
  assign cur_mask = mask;
endmodule

// File: rtl/nirq_chk.sv
module nirq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gie,
  input logic       xfer_busy,
  input logic       reti,
  input logic       ack,
  input logic [2:0] cur_mask,
  input logic       stk_ovf,
  input logic       stk_unf
);
  AST_ACK_LOWERS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (cur_mask < $past(cur_mask)));                           // R2
  AST_NEVER_LVL7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (cur_mask != 3'd7));                                     // R3
  AST_GIE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(gie));                                             // R4
  AST_XFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !$past(xfer_busy));                                      // R8
  AST_RETI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !$past(reti));                                           // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stk_ovf) |-> stk_ovf);                                     // R11
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stk_unf) |-> stk_unf);                                     // R12
endmodule

bind nest_irq_ctrl nirq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_ni),
  .gie       (gie),
  .xfer_busy (xfer_busy),
  .reti      (reti),
  .ack       (ack),
  .cur_mask  (cur_mask),
  .stk_ovf   (stk_ovf),
  .stk_unf   (stk_unf)
);

// File: tb/tb_nest_irq_ctrl.sv
module tb_nest_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq;
  logic       gie, xfer, reti, we;
  logic [2:0] cidx, clvl;
  logic       ack, ovf, unf;
  logic [2:0] ack_idx, cur_mask;

  logic [7:0] s_irq;
  logic       s_reti, s_we;
  logic [2:0] s_cidx, s_clvl;
  logic       s_ack, s_ovf, s_unf;
  logic [2:0] s_idx, s_mask;

  int vecs = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  int m_pend [8];
  int m_lvl  [8];
  int m_stk  [8];
  int m_mask, m_cnt, m_ovf, m_unf, m_ack, m_idx;

  always #10 clk = ~clk;

  nest_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq), .gie(gie), .xfer_busy(xfer),
    .reti(reti), .cfg_we(we), .cfg_idx(cidx), .cfg_lvl(clvl),
    .ack(ack), .ack_idx(ack_idx), .cur_mask(cur_mask), .stk_ovf(ovf), .stk_unf(unf)
  );

  nest_irq_ctrl #(.STK_DEPTH(4)) dut_s (
    .clk(clk), .rst_n(rst_n), .irq_req(s_irq), .gie(1'b1), .xfer_busy(1'b0),
    .reti(s_reti), .cfg_we(s_we), .cfg_idx(s_cidx), .cfg_lvl(s_clvl),
    .ack(s_ack), .ack_idx(s_idx), .cur_mask(s_mask), .stk_ovf(s_ovf), .stk_unf(s_unf)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin m_pend[i] = 0; m_lvl[i] = 7; m_stk[i] = 0; end
    m_mask = 7; m_cnt = 0; m_ovf = 0; m_unf = 0; m_ack = 0; m_idx = 0;
  endtask

  task automatic model_step();
    int best, bl, acc;
    best = -1; bl = 7;
    for (int i = 0; i < 8; i++)
      if (m_pend[i] != 0 && m_lvl[i] < m_mask && (best < 0 || m_lvl[i] < bl)) begin
        best = i; bl = m_lvl[i];
      end
    acc = (best >= 0 && gie && !xfer && !reti) ? 1 : 0;
    for (int i = 0; i < 8; i++)
      m_pend[i] = (irq[i] || (m_pend[i] != 0 && !(acc != 0 && best == i))) ? 1 : 0;
    if (reti) begin
      if (m_cnt > 0) begin m_cnt--; m_mask = m_stk[m_cnt]; end
      else m_unf = 1;
    end else if (acc != 0) begin
      if (m_cnt < 8) begin m_stk[m_cnt] = m_mask; m_cnt++; end
      else m_ovf = 1;
      m_mask = bl;
    end
    m_ack = acc;
    if (acc != 0) m_idx = best;
    if (we) m_lvl[cidx] = int'(clvl);
  endtask

  task automatic drv(input logic [7:0] i, input logic g, input logic x, input logic r,
                     input logic w, input int wi, input int wl);
    irq = i; gie = g; xfer = x; reti = r; we = w; cidx = 3'(wi); clvl = 3'(wl);
  endtask

  task automatic cyc(input string tag);
    model_step();
    @(posedge clk); #5;
    cmp(tag, int'(ack), m_ack);
    if (m_ack != 0) cmp(tag, int'(ack_idx), m_idx);
    cmp("R6", int'(cur_mask), m_mask);
    cmp("R11", int'(ovf), m_ovf);
    cmp("R12", int'(unf), m_unf);
  endtask

  task automatic idle(input string tag);
    drv(8'h00, 1, 0, 0, 0, 0, 0); cyc(tag);
  endtask

  task automatic cfg(input int i, input int l, input string tag);
    drv(8'h00, 1, 0, 0, 1, i, l); cyc(tag);
  endtask

  task automatic do_reti(input string tag);
    drv(8'h00, 1, 0, 1, 0, 0, 0); cyc(tag);
  endtask

  task automatic s_step();
    @(posedge clk); #5;
    s_irq = 8'h00; s_reti = 0; s_we = 0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0;
    drv(8'h00, 1, 0, 0, 0, 0, 0);
    s_irq = 0; s_reti = 0; s_we = 0; s_cidx = 0; s_clvl = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    repeat (4) @(posedge clk);
    #5;
    // R1 reset state
    cmp("R1", int'(ack), 0);
    cmp("R1", int'(cur_mask), 7);
    cmp("R1", int'(ovf), 0);
    cmp("R1", int'(unf), 0);

    // R3: level 7 never taken; R1: write opens it
    cfg(2, 7, "R1");
    drv(8'h04, 1, 0, 0, 0, 0, 0); cyc("R3");
    repeat (3) begin idle("R3"); cmp("R3", int'(ack), 0); end
    cfg(2, 3, "R1");
    idle("R1");
    cmp("R1", int'(ack), 1); cmp("R1", int'(ack_idx), 2); cmp("R2", int'(cur_mask), 3);

    // R7: equal level waits for return
    cfg(5, 3, "R7");
    drv(8'h20, 1, 0, 0, 0, 0, 0); cyc("R7");
    repeat (2) begin idle("R7"); cmp("R7", int'(ack), 0); end
    do_reti("R6");
    cmp("R6", int'(cur_mask), 7);
    idle("R7");
    cmp("R7", int'(ack), 1); cmp("R7", int'(ack_idx), 5);
    do_reti("R6");

    // R4: global enable off holds, on releases
    cfg(1, 2, "R4");
    drv(8'h02, 0, 0, 0, 0, 0, 0); cyc("R4");
    repeat (3) begin drv(8'h00, 0, 0, 0, 0, 0, 0); cyc("R4"); cmp("R4", int'(ack), 0); end
    idle("R4");
    cmp("R4", int'(ack), 1); cmp("R4", int'(ack_idx), 1);
    do_reti("R6");

    // R8: transfer service holds everything
    cfg(0, 1, "R8");
    drv(8'h01, 1, 1, 0, 0, 0, 0); cyc("R8");
    repeat (2) begin drv(8'h00, 1, 1, 0, 0, 0, 0); cyc("R8"); cmp("R8", int'(ack), 0); end
    idle("R8");
    cmp("R8", int'(ack), 1); cmp("R8", int'(ack_idx), 0);
    do_reti("R6");

    // R10: return in the decision cycle blocks, then stronger one taken
    cfg(3, 5, "R10");
    cfg(4, 1, "R10");
    drv(8'h08, 1, 0, 0, 0, 0, 0); cyc("R10");
    idle("R10");
    cmp("R10", int'(ack_idx), 3);
    drv(8'h10, 1, 0, 0, 0, 0, 0); cyc("R10");
    do_reti("R10");
    cmp("R10", int'(ack), 0); cmp("R10", int'(cur_mask), 7);
    idle("R10");
    cmp("R10", int'(ack), 1); cmp("R10", int'(ack_idx), 4);
    do_reti("R6");

    // R5: level tie goes to lower index
    cfg(6, 2, "R5");
    cfg(7, 2, "R5");
    drv(8'hC0, 1, 0, 0, 0, 0, 0); cyc("R5");
    idle("R5");
    cmp("R5", int'(ack), 1); cmp("R5", int'(ack_idx), 6);
    idle("R5");
    cmp("R5", int'(ack), 0);
    do_reti("R5");
    idle("R5");
    cmp("R5", int'(ack_idx), 7);
    do_reti("R6");

    // R9: held request re-arms on accept; a pulse does not
    drv(8'h01, 1, 0, 0, 0, 0, 0); cyc("R9");
    cyc("R9");
    cmp("R9", int'(ack), 1);
    drv(8'h01, 1, 0, 1, 0, 0, 0); cyc("R9");
    drv(8'h00, 1, 0, 0, 0, 0, 0); cyc("R9");
    cmp("R9", int'(ack), 1); cmp("R9", int'(ack_idx), 0);
    do_reti("R9");
    idle("R9");
    cmp("R9", int'(ack), 0);

    // R3: mask 0 blocks all
    cfg(0, 0, "R3");
    drv(8'h01, 1, 0, 0, 0, 0, 0); cyc("R3");
    idle("R3");
    cmp("R3", int'(cur_mask), 0);
    drv(8'h02, 1, 0, 0, 0, 0, 0); cyc("R3");
    repeat (2) begin idle("R3"); cmp("R3", int'(ack), 0); end
    do_reti("R3");
    idle("R3");
    cmp("R3", int'(ack_idx), 1);

    // R12: drain and underflow keeps mask
    repeat (10) do_reti("R12");
    cmp("R12", int'(unf), 1);
    cmp("R12", int'(cur_mask), 7);

    // random phase checked against the model
    for (int k = 0; k < 4000; k++) begin
      drv((($urandom % 4) == 0) ? (8'($urandom) & 8'($urandom)) : 8'h00,
          ($urandom % 8) != 0, ($urandom % 10) == 0, ($urandom % 5) == 0,
          ($urandom % 12) == 0, int'($urandom % 8), int'($urandom % 8));
      cyc("R2");
    end
    drv(8'h00, 1, 0, 0, 0, 0, 0);

    // R11: four-deep stack overflows on the fifth nested accept
    for (int i = 0; i < 6; i++) begin
      s_we = 1; s_cidx = 3'(i); s_clvl = 3'(6 - i); s_step();
    end
    for (int i = 0; i < 6; i++) begin
      s_irq = 8'(1 << i); s_step();
      s_step();
      cmp("R11", int'(s_ack), 1);
      cmp("R11", int'(s_mask), 6 - i);
      cmp("R11", int'(s_ovf), (i >= 4) ? 1 : 0);
    end
    s_reti = 1; s_step();
    cmp("R11", int'(s_ovf), 1);
    summary();
  end
endmodule